// File: doc/BRIEF.md
# Retransmit-Once Reassembly Slot Controller

This block sits on the receiving side of a network node. It owns a small pool of reassembly slots into which the flits of multi-flit packets are gathered. A packet is identified by its source node and request number. The first flit seen for an unknown packet claims a free slot. Later flits of the same packet are steered to that slot, in any sequence order, until every sequence number has arrived. When that happens the block reports the packet as complete. The slot then stays occupied until the requester gives it back with a release event.

Senders never ask for space before they send. When no slot is free, the packet is dropped and a single negative acknowledgement goes back to its source. The dropped packet's identity is queued in a small first-in first-out pending list. Later flits of that packet are discarded without further notice. As soon as any slot becomes free, it is reserved for the oldest queued packet and a retransmit request names the packet and the slot. Only that packet can fill a reserved slot, so every dropped packet is resent exactly once. All outputs are registered single-cycle pulses.

Top module: `reasm_ctrl`

## Requirements
- R1: After reset, nack_vld, rtx_vld, wr_vld and done_vld are all low.
- R2: A flit whose (source, request) matches no slot and no pending entry claims the lowest-numbered free slot not being reserved in the same cycle. Each accepted flit is reported the next cycle on wr_vld, with wr_slot and wr_seq equal to that slot and the flit's sequence number.
- R3: done_vld pulses once, with done_slot, in the cycle after the flit that completes all NFLIT sequence numbers of a packet, whatever order those numbers arrived in.
- R4: When no slot can be claimed, the packet is dropped. Exactly one nack_vld pulse carries its source and request the next cycle, and its later flits produce no wr_vld, nack_vld or done_vld.
- R5: A slot that becomes free while the pending list is non-empty is reserved in the following cycle. rtx_vld is visible the cycle after that, with the packet's source and request and the slot index, so it appears two cycles after a release of that slot. When several slots are free, the highest-numbered one is reserved.
- R6: Pending packets receive retransmit requests in the order in which they were dropped. Up to PEND_DEPTH packets may be pending at once.
- R7: A reserved slot is never claimed by another new packet; such a packet is dropped and NACKed as in R4.
- R8: Flits of a retransmitted packet are written into the slot reserved for it and complete there as in R3.
- R9: A completed slot stays held, ignoring further flits of its packet, until a release names it. A release naming a free slot has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flit_vld | input | 1 | A flit arrives this cycle |
| flit_src | input | SRC_W | Source node of the flit |
| flit_req | input | REQ_W | Request number of the flit |
| flit_seq | input | SEQ_W | Sequence number of the flit within its packet |
| rel_vld | input | 1 | Requester releases a slot |
| rel_slot | input | SLOT_W | Slot being released |
| nack_vld | output | 1 | Negative acknowledgement pulse |
| nack_src | output | SRC_W | Source of the dropped packet |
| nack_req | output | REQ_W | Request number of the dropped packet |
| rtx_vld | output | 1 | Retransmit request pulse |
| rtx_src | output | SRC_W | Source asked to retransmit |
| rtx_req | output | REQ_W | Request number to retransmit |
| rtx_slot | output | SLOT_W | Slot reserved for the retransmission |
| wr_vld | output | 1 | Flit accepted into a slot |
| wr_slot | output | SLOT_W | Slot receiving the flit |
| wr_seq | output | SEQ_W | Sequence number of the accepted flit |
| done_vld | output | 1 | Packet complete pulse |
| done_slot | output | SLOT_W | Slot holding the completed packet |

## Verification
A corrupted slot key or state shows at the ports on the very next flit of that packet. The flit either lands in the wrong slot on wr_slot or draws a spurious NACK. A lost collection bit shows as done_vld missing after the last flit of a packet. A pending list that loses order or an entry shows as a retransmit request naming the wrong packet, two cycles after the release that should have triggered it. A slot wrongly freed shows on the following new packet, which is accepted where a NACK was due. Sweeping all arrival orders generated by strides 1 and 3 from every start position exposes each of these within a few cycles.

// File: rtl/reasm_pkg.sv
package reasm_pkg;

    typedef enum logic [1:0] {
        SL_FREE = 2'd0,
        SL_HELD = 2'd1,
        SL_FILL = 2'd2,
        SL_DONE = 2'd3
    } slot_st_e;

    // index of the lowest set bit (0 when none)
    function automatic int unsigned low_idx(input logic [63:0] v);
        int unsigned r;
        r = 0;
        for (int i = 63; i >= 0; i--) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction

    // index of the highest set bit (0 when none)
    function automatic int unsigned high_idx(input logic [63:0] v);
        int unsigned r;
        r = 0;
        for (int i = 0; i < 64; i++) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/reasm_pend_fifo.sv
module reasm_pend_fifo #(
    parameter int W     = 5,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    input  logic [W-1:0] probe,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full,
    output logic         probe_hit
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     mem [DEPTH];
    logic [DEPTH-1:0] used;
    logic [PTR_W-1:0] wp, rp;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = !used[rp];
    assign full  = used[wp];
    assign head  = mem[rp];

    always_comb begin
        probe_hit = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (used[i] && mem[i] == probe) probe_hit = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            used <= '0;
            wp   <= '0;
            rp   <= '0;
        end else begin
            if (pop) begin
                used[rp] <= 1'b0;
                rp       <= nxt(rp);
            end
            if (push) begin
                mem[wp]  <= push_data;
                used[wp] <= 1'b1;
                wp       <= nxt(wp);
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push |-> (!full || pop)); // R6
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty); // R5

endmodule

// File: rtl/reasm_slot.sv
module reasm_slot
    import reasm_pkg::*;
#(
    parameter int KEY_W = 5,
    parameter int NFLIT = 4,
    parameter int SEQ_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rel_en,
    input  logic             res_en,
    input  logic [KEY_W-1:0] res_key,
    input  logic             alloc_en,
    input  logic             upd_en,
    input  logic [KEY_W-1:0] flit_key,
    input  logic [SEQ_W-1:0] seq,
    output slot_st_e         st_o,
    output logic             match_o,
    output logic             acc_o,
    output logic             fin_o
);
    slot_st_e         st;
    logic [KEY_W-1:0] key;
    logic [NFLIT-1:0] mask, seq_bit, fill_nxt;
    logic             open_slot, full;

    assign seq_bit   = NFLIT'(1) << seq;
    assign fill_nxt  = (alloc_en ? '0 : mask) | seq_bit;
    assign full      = &fill_nxt;
    assign open_slot = (st == SL_HELD) || (st == SL_FILL);

    assign st_o    = st;
    assign match_o = (st != SL_FREE) && (key == flit_key);
    assign acc_o   = alloc_en || (upd_en && open_slot);
    assign fin_o   = acc_o && full;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= SL_FREE;
            key  <= '0;
            mask <= '0;
        end else if (rel_en && st != SL_FREE) begin
            st   <= SL_FREE;
            mask <= '0;
        end else if (res_en) begin
            st   <= SL_HELD;
            key  <= res_key;
            mask <= '0;
        end else if (alloc_en) begin
            key  <= flit_key;
            mask <= fill_nxt;
            st   <= full ? SL_DONE : SL_FILL;
        end else if (upd_en && open_slot) begin
            mask <= fill_nxt;
            st   <= full ? SL_DONE : SL_FILL;
        end
    end

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st == SL_DONE && !rel_en) |=> (st == SL_DONE)); // R9
    AST_HELD_KEEP: assert property (@(posedge clk) disable iff (rst)
        (st == SL_HELD && !rel_en && !upd_en) |=> (st == SL_HELD && $stable(key))); // R7

endmodule

// File: rtl/reasm_ctrl.sv
module reasm_ctrl
    import reasm_pkg::*;
#(
    parameter int NSLOT      = 2,
    parameter int NFLIT      = 4,
    parameter int SRC_W      = 3,
    parameter int REQ_W      = 2,
    parameter int PEND_DEPTH = 4,
    localparam int SEQ_W     = (NFLIT > 1) ? $clog2(NFLIT) : 1,
    localparam int SLOT_W    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flit_vld,
    input  logic [SRC_W-1:0]  flit_src,
    input  logic [REQ_W-1:0]  flit_req,
    input  logic [SEQ_W-1:0]  flit_seq,
    input  logic              rel_vld,
    input  logic [SLOT_W-1:0] rel_slot,
    output logic              nack_vld,
    output logic [SRC_W-1:0]  nack_src,
    output logic [REQ_W-1:0]  nack_req,
    output logic              rtx_vld,
    output logic [SRC_W-1:0]  rtx_src,
    output logic [REQ_W-1:0]  rtx_req,
    output logic [SLOT_W-1:0] rtx_slot,
    output logic              wr_vld,
    output logic [SLOT_W-1:0] wr_slot,
    output logic [SEQ_W-1:0]  wr_seq,
    output logic              done_vld,
    output logic [SLOT_W-1:0] done_slot
);
    localparam int KEY_W = SRC_W + REQ_W;

    logic [KEY_W-1:0]  flit_key, head_key;
    slot_st_e          st [NSLOT];
    logic [NSLOT-1:0]  match_v, acc_v, fin_v, free_v, rel_v, upd_v;
    logic [NSLOT-1:0]  res_v, alloc_v, avail_v;
    logic              pend_empty, pend_full, pend_hit;
    logic              res_go, new_pkt, alloc_go, drop_go;
    logic [SLOT_W-1:0] res_idx, alloc_idx, acc_idx, fin_idx;

    assign flit_key = {flit_src, flit_req};

    always_comb begin
        for (int i = 0; i < NSLOT; i++) begin
            free_v[i] = (st[i] == SL_FREE);
            rel_v[i]  = rel_vld && (rel_slot == SLOT_W'(i)) && (st[i] != SL_FREE);
            upd_v[i]  = flit_vld && match_v[i] && !rel_v[i];
        end
    end

    assign res_go    = !pend_empty && (|free_v);
    assign res_idx   = SLOT_W'(high_idx(64'(free_v)));
    assign res_v     = res_go ? (NSLOT'(1) << res_idx) : '0;
    assign avail_v   = free_v & ~res_v;
    assign alloc_idx = SLOT_W'(low_idx(64'(avail_v)));
    assign new_pkt   = flit_vld && !(|match_v) && !pend_hit;
    assign alloc_go  = new_pkt && (|avail_v);
    assign drop_go   = new_pkt && !(|avail_v);
    assign alloc_v   = alloc_go ? (NSLOT'(1) << alloc_idx) : '0;
    assign acc_idx   = SLOT_W'(low_idx(64'(acc_v)));
    assign fin_idx   = SLOT_W'(low_idx(64'(fin_v)));

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        reasm_slot #(
            .KEY_W (KEY_W),
            .NFLIT (NFLIT),
            .SEQ_W (SEQ_W)
        ) u_slot (
            .clk      (clk),
            .rst      (rst),
            .rel_en   (rel_v[g]),
            .res_en   (res_v[g]),
            .res_key  (head_key),
            .alloc_en (alloc_v[g]),
            .upd_en   (upd_v[g]),
            .flit_key (flit_key),
            .seq      (flit_seq),
            .st_o     (st[g]),
            .match_o  (match_v[g]),
            .acc_o    (acc_v[g]),
            .fin_o    (fin_v[g])
        );
    end

    reasm_pend_fifo #(
        .W     (KEY_W),
        .DEPTH (PEND_DEPTH)
    ) u_pend (
        .clk       (clk),
        .rst       (rst),
        .push      (drop_go),
        .push_data (flit_key),
        .pop       (res_go),
        .probe     (flit_key),
        .head      (head_key),
        .empty     (pend_empty),
        .full      (pend_full),
        .probe_hit (pend_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            nack_vld  <= 1'b0;
            nack_src  <= '0;
            nack_req  <= '0;
            rtx_vld   <= 1'b0;
            rtx_src   <= '0;
            rtx_req   <= '0;
            rtx_slot  <= '0;
            wr_vld    <= 1'b0;
            wr_slot   <= '0;
            wr_seq    <= '0;
            done_vld  <= 1'b0;
            done_slot <= '0;
        end else begin
            nack_vld  <= drop_go;
            nack_src  <= flit_src;
            nack_req  <= flit_req;
            rtx_vld   <= res_go;
            rtx_src   <= head_key[KEY_W-1:REQ_W];
            rtx_req   <= head_key[REQ_W-1:0];
            rtx_slot  <= res_idx;
            wr_vld    <= |acc_v;
            wr_slot   <= acc_idx;
            wr_seq    <= flit_seq;
            done_vld  <= |fin_v;
            done_slot <= fin_idx;
        end
    end

    AST_RTX_HELD: assert property (@(posedge clk) disable iff (rst)
        rtx_vld |-> (st[rtx_slot] == SL_HELD)); // R5
    AST_NACK_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(nack_vld && wr_vld)); // R4
    AST_DONE_WR: assert property (@(posedge clk) disable iff (rst)
        done_vld |-> (wr_vld && wr_slot == done_slot)); // R3
    AST_ONE_ACC: assert property (@(posedge clk) disable iff (rst)
        $onehot0(acc_v)); // R2

endmodule

// File: tb/reasm_ctrl_tb.sv
module reasm_ctrl_tb;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       flit_vld = 1'b0;
    logic [2:0] flit_src = '0;
    logic [1:0] flit_req = '0;
    logic [1:0] flit_seq = '0;
    logic       rel_vld = 1'b0;
    logic [0:0] rel_slot = '0;
    logic       nack_vld, rtx_vld, wr_vld, done_vld;
    logic [2:0] nack_src, rtx_src;
    logic [1:0] nack_req, rtx_req, wr_seq;
    logic [0:0] rtx_slot, wr_slot, done_slot;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    reasm_ctrl u_dut (
        .clk(clk), .rst(rst),
        .flit_vld(flit_vld), .flit_src(flit_src), .flit_req(flit_req), .flit_seq(flit_seq),
        .rel_vld(rel_vld), .rel_slot(rel_slot),
        .nack_vld(nack_vld), .nack_src(nack_src), .nack_req(nack_req),
        .rtx_vld(rtx_vld), .rtx_src(rtx_src), .rtx_req(rtx_req), .rtx_slot(rtx_slot),
        .wr_vld(wr_vld), .wr_slot(wr_slot), .wr_seq(wr_seq),
        .done_vld(done_vld), .done_slot(done_slot)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one clock: drive, pass the edge, sample 1 time unit later
    task automatic cyc(input bit fv, input int src, input int req, input int seq,
                       input bit rv, input int rs);
        flit_vld = fv;
        flit_src = 3'(src);
        flit_req = 2'(req);
        flit_seq = 2'(seq);
        rel_vld  = rv;
        rel_slot = 1'(rs);
        @(posedge clk);
        #1;
    endtask

    task automatic idle_cyc();
        cyc(0, 0, 0, 0, 0, 0);
    endtask

    // four flits ordered by seq = (k*m + off) mod 4; exp_slot < 0 means dropped
    task automatic pkt(input int src, input int req, input int m, input int off, input int exp_slot);
        for (int k = 0; k < 4; k++) begin
            int s;
            s = (k * m + off) % 4;
            cyc(1, src, req, s, 0, 0);
            if (exp_slot >= 0) begin
                chk("R2 wr_vld", wr_vld, 1);
                chk("R2/R8 wr_slot", wr_slot, exp_slot);
                chk("R2 wr_seq", wr_seq, s);
                chk("R4 no nack on accept", nack_vld, 0);
                chk("R3 done_vld", done_vld, (k == 3) ? 1 : 0);
                if (k == 3) chk("R3 done_slot", done_slot, exp_slot);
            end else begin
                chk("R4 one nack", nack_vld, (k == 0) ? 1 : 0);
                chk("R4 dropped no wr", wr_vld, 0);
                chk("R4 dropped no done", done_vld, 0);
                if (k == 0) begin
                    chk("R4 nack_src", nack_src, src);
                    chk("R4 nack_req", nack_req, req);
                end
            end
        end
    endtask

    task automatic release_slot(input int rs);
        cyc(0, 0, 0, 0, 1, rs);
        chk("R5 no rtx at release edge", rtx_vld, 0);
    endtask

    task automatic expect_rtx(input int src, input int req, input int slot);
        idle_cyc();
        chk("R5 rtx_vld", rtx_vld, 1);
        chk("R6 rtx_src", rtx_src, src);
        chk("R6 rtx_req", rtx_req, req);
        chk("R5 rtx_slot", rtx_slot, slot);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R1: reset state
        chk("R1 nack_vld", nack_vld, 0);
        chk("R1 rtx_vld", rtx_vld, 0);
        chk("R1 wr_vld", wr_vld, 0);
        chk("R1 done_vld", done_vld, 0);

        // sweep arrival orders (strides 1 and 3, all offsets)
        for (int mi = 0; mi < 2; mi++) begin
            for (int off = 0; off < 4; off++) begin
                int m;
                m = (mi == 0) ? 1 : 3;
                pkt(1, off, m, off, 0);
                pkt(2, off, 4 - m, 3 - off, 1);
                // R9: late duplicate flit to a completed slot is ignored
                cyc(1, 1, off, off, 0, 0);
                chk("R9 dup no wr", wr_vld, 0);
                chk("R9 dup no nack", nack_vld, 0);
                chk("R9 dup no done", done_vld, 0);
                release_slot(0);
                release_slot(1);
                idle_cyc();
                chk("R5 no rtx when nothing pending", rtx_vld, 0);
            end
        end

        // drop / reserve / retransmit flow
        pkt(1, 0, 1, 0, 0);          // A -> slot0
        pkt(2, 1, 3, 1, 1);          // B -> slot1
        pkt(3, 2, 1, 2, -1);         // C dropped
        pkt(4, 3, 3, 0, -1);         // D dropped
        pkt(5, 0, 1, 1, -1);         // F dropped
        release_slot(1);
        expect_rtx(3, 2, 1);         // oldest C takes slot1
        pkt(6, 1, 1, 3, -1);         // R7: E cannot take reserved slot
        pkt(3, 2, 3, 2, 1);          // R8: C retransmission into slot1
        release_slot(0);
        expect_rtx(4, 3, 0);         // R6: D next
        release_slot(1);
        expect_rtx(5, 0, 1);         // R6: then F
        pkt(4, 3, 1, 0, 0);          // R8
        pkt(5, 0, 3, 3, 1);          // R8
        release_slot(0);
        expect_rtx(6, 1, 0);         // R6: then E
        pkt(6, 1, 1, 2, 0);          // R8
        release_slot(1);
        idle_cyc();
        chk("R6 pending list drained", rtx_vld, 0);
        release_slot(0);
        cyc(0, 0, 0, 0, 1, 0);       // R9: release of a free slot
        chk("R9 free release no rtx", rtx_vld, 0);
        pkt(7, 2, 1, 0, 0);          // R9: slot0 still free, lowest first
        pkt(7, 3, 3, 0, 1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule